// File: doc/BRIEF.md
# Handshake Request Counter and Interrupt Unit

This block keeps count of handshake-style memory transfer requests and turns their progress into interrupts. A pulse-style request line is watched for rising edges. Each edge adds one to a pending-request counter, and each transfer-complete strobe takes one away. A second counter measures out blocks of transfers. It is loaded from a block-length register and reloads itself from that register on the transfer that ends a block, so the next block starts without a gap.

Two interrupt causes are recorded as sticky status bits in a control word.
- **Block done** is raised when a block finishes. If the hold option is set, it is delayed until the pending-request counter has also drained to zero.
- **Overflow** is raised whenever the pending count is above a programmable threshold. The threshold resets to all ones, so overflow stays quiet until software lowers it.

Software reads and writes everything through a small register port. It clears status bits by writing ones to them. The interrupt line is the OR of each status bit masked by its enable.

Top module: `hsreq_irq_unit`

## Requirements
- R1: After reset the control word (address 0), the block length (address 1), the block counter (address 2) and the pending count (address 3) read 0, the threshold (address 4) reads 0xFFFF, and `irq` is low.
- R2: The pending count, read at address 3, rises by one in the cycle after a clock in which `req_in` is high having been low the clock before. A level held high counts once. It falls by one after a clock with `xfer_done` high. A clock with both a new edge and `xfer_done` leaves it unchanged.
- R3: The pending count never goes above 32767 and never below 0. Extra edges at the top and extra strobes at zero leave it unchanged.
- R4: Writing address 1 sets both the block length and the block counter. Each `xfer_done` lowers the block counter by one. The strobe that would take the counter from 1 to 0 reloads the block length instead. A counter of 0 ignores strobes. Writes to addresses 2 and 3 are ignored.
- R5: With control bit 1 (hold) clear, control bit 8 (block-done status) reads 1 from the cycle after the strobe that ends a block.
- R6: With hold set, block-done status is withheld while the pending count, including that cycle's change, is non-zero. It sets in the cycle after the pending count reaches zero.
- R7: Control bit 9 (overflow status) sets in the cycle after a clock in which the pending count exceeds the threshold at address 4.
- R8: Writing 1 to control bit 8 or 9 clears that status bit, and writing 0 to it leaves it unchanged. A status set and a clearing write in the same clock leave the bit set.
- R9: `irq` is high exactly when (bit 8 and bit 0, block-done enable) or (bit 9 and bit 2, overflow enable) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 1 | Handshake request line, counted on rising edges |
| xfer_done | input | 1 | One-cycle strobe per completed transfer |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The test covers two pairs of events that can land in the same clock.

**New request edge with a transfer strobe.** The bench raises `req_in` in the same clock that it pulses `xfer_done`. It then expects the pending count to be unchanged.

**Status set with a clearing write.** The bench writes a 1 to block-done status in the exact cycle whose strobe ends a block. It does the same for overflow status while the count is still above the threshold. In both cases it expects the bit to survive, and then to clear on a later write.

// File: rtl/hsreq_pkg.sv
package hsreq_pkg;
   // register map (3-bit address)
   localparam int REG_AW = 3;
   localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
   localparam logic [REG_AW-1:0] A_BLEN  = 3'd1;
   localparam logic [REG_AW-1:0] A_BCNT  = 3'd2;
   localparam logic [REG_AW-1:0] A_PEND  = 3'd3;
   localparam logic [REG_AW-1:0] A_THR   = 3'd4;

   // control word bit positions
   localparam int CB_BLK_IE  = 0;
   localparam int CB_HOLD    = 1;
   localparam int CB_OVF_IE  = 2;
   localparam int CB_BLK_ST  = 8;
   localparam int CB_OVF_ST  = 9;

   // status vector indices
   localparam int ST_BLK = 0;
   localparam int ST_OVF = 1;
   localparam int N_ST   = 2;

   typedef struct packed {
      logic ovf_ie;
      logic hold;
      logic blk_ie;
   } ctl_en_t;
endpackage

// File: rtl/hsreq_edge_ctr.sv
module hsreq_edge_ctr #(
   parameter int EDGE_W      = 15,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_in,
   input  logic              xfer_done,
   output logic              rise,
   output logic [EDGE_W-1:0] cnt,
   output logic [EDGE_W-1:0] cnt_nxt
);
   localparam logic [EDGE_W-1:0] CNT_MAX = '1;
   localparam logic [EDGE_W-1:0] ONE     = EDGE_W'(1);

   if (EDGE_W < 2) begin : g_bad_w
      $error("hsreq_edge_ctr: EDGE_W must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("hsreq_edge_ctr: SYNC_STAGES must be 0..4");
   end

   logic req_s;
   logic req_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign req_s = req_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= (sh << 1) | SYNC_STAGES'(req_in);
      end
      assign req_s = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req_s;
   end

   assign rise = req_s & ~req_q;

   always_comb begin
      cnt_nxt = cnt;
      unique case ({rise, xfer_done})
         2'b10:   if (cnt != CNT_MAX) cnt_nxt = cnt + ONE;
         2'b01:   if (cnt != '0)      cnt_nxt = cnt - ONE;
         default: cnt_nxt = cnt;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end
endmodule

// File: rtl/hsreq_blk_ctr.sv
module hsreq_blk_ctr #(
   parameter int BLK_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BLK_W-1:0] load_val,
   input  logic             xfer_done,
   output logic [BLK_W-1:0] len,
   output logic [BLK_W-1:0] cnt,
   output logic             hit
);
   localparam logic [BLK_W-1:0] ONE = BLK_W'(1);

   if (BLK_W < 1) begin : g_bad_w
      $error("hsreq_blk_ctr: BLK_W must be positive");
   end

   assign hit = xfer_done & ~load & (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len <= '0;
         cnt <= '0;
      end else if (load) begin
         len <= load_val;
         cnt <= load_val;
      end else if (xfer_done && cnt != '0) begin
         cnt <= (cnt == ONE) ? len : cnt - ONE;
      end
   end
endmodule

// File: rtl/hsreq_ctl_regs.sv
module hsreq_ctl_regs
   import hsreq_pkg::*;
#(
   parameter int EDGE_W = 15,
   parameter int THR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [2:0]        en_wdata,
   input  logic [N_ST-1:0]   st_w1c,
   input  logic              thr_we,
   input  logic [THR_W-1:0]  thr_wdata,
   input  logic              blk_hit,
   input  logic              pend_nxt_zero,
   input  logic [EDGE_W-1:0] pend_cnt,
   output ctl_en_t           en,
   output logic [N_ST-1:0]   st,
   output logic [THR_W-1:0]  thr,
   output logic              irq
);
   localparam int CMP_W = (EDGE_W > THR_W) ? EDGE_W : THR_W;

   logic            blk_arm;
   logic            blk_rel;
   logic            blk_wait;
   logic            ovf_hit;
   logic [N_ST-1:0] st_set;
   logic [N_ST-1:0] en_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= '0;
      else if (ctl_we) en <= ctl_en_t'(en_wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      thr <= '1;
      else if (thr_we) thr <= thr_wdata;
   end

   // block-done: armed by the block end, released once hold permits
   assign blk_arm = blk_hit | blk_wait;
   assign blk_rel = blk_arm & (~en.hold | pend_nxt_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blk_wait <= 1'b0;
      else        blk_wait <= blk_arm & ~blk_rel;
   end

   assign ovf_hit = CMP_W'(pend_cnt) > CMP_W'(thr);

   assign st_set[ST_BLK] = blk_rel;
   assign st_set[ST_OVF] = ovf_hit;
   assign en_vec[ST_BLK] = en.blk_ie;
   assign en_vec[ST_OVF] = en.ovf_ie;

   for (genvar i = 0; i < N_ST; i++) begin : g_st
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[i] <= 1'b0;
         else        st[i] <= (st[i] & ~(ctl_we & st_w1c[i])) | st_set[i];
      end
   end

   assign irq = |(st & en_vec);
endmodule

// File: rtl/hsreq_irq_unit.sv
module hsreq_irq_unit
   import hsreq_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int EDGE_W      = 15,
   parameter int BLK_W       = 16,
   parameter int THR_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_in,
   input  logic              xfer_done,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   if (DATA_W < CB_OVF_ST + 1) begin : g_bad_data
      $error("hsreq_irq_unit: DATA_W too narrow for control word");
   end
   if (EDGE_W > DATA_W || BLK_W > DATA_W || THR_W > DATA_W) begin : g_bad_fit
      $error("hsreq_irq_unit: counter or threshold wider than data port");
   end

   logic              edge_rise;
   logic [EDGE_W-1:0] pend_cnt;
   logic [EDGE_W-1:0] pend_nxt;
   logic [BLK_W-1:0]  blk_len;
   logic [BLK_W-1:0]  blk_cnt;
   logic              blk_hit;
   ctl_en_t           en;
   logic [N_ST-1:0]   st;
   logic [THR_W-1:0]  thr;
   logic              we_ctrl;
   logic              we_blen;
   logic              we_thr;
   logic [N_ST-1:0]   w1c;

   assign we_ctrl = reg_we && (reg_addr == A_CTRL);
   assign we_blen = reg_we && (reg_addr == A_BLEN);
   assign we_thr  = reg_we && (reg_addr == A_THR);
   assign w1c[ST_BLK] = reg_wdata[CB_BLK_ST];
   assign w1c[ST_OVF] = reg_wdata[CB_OVF_ST];

   hsreq_edge_ctr #(.EDGE_W(EDGE_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_in    (req_in),
      .xfer_done (xfer_done),
      .rise      (edge_rise),
      .cnt       (pend_cnt),
      .cnt_nxt   (pend_nxt)
   );

   hsreq_blk_ctr #(.BLK_W(BLK_W)) u_blk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (we_blen),
      .load_val  (reg_wdata[BLK_W-1:0]),
      .xfer_done (xfer_done),
      .len       (blk_len),
      .cnt       (blk_cnt),
      .hit       (blk_hit)
   );

   hsreq_ctl_regs #(.EDGE_W(EDGE_W), .THR_W(THR_W)) u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_we        (we_ctrl),
      .en_wdata      ({reg_wdata[CB_OVF_IE], reg_wdata[CB_HOLD], reg_wdata[CB_BLK_IE]}),
      .st_w1c        (w1c),
      .thr_we        (we_thr),
      .thr_wdata     (reg_wdata[THR_W-1:0]),
      .blk_hit       (blk_hit),
      .pend_nxt_zero (pend_nxt == '0),
      .pend_cnt      (pend_cnt),
      .en            (en),
      .st            (st),
      .thr           (thr),
      .irq           (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[CB_BLK_IE] = en.blk_ie;
            reg_rdata[CB_HOLD]   = en.hold;
            reg_rdata[CB_OVF_IE] = en.ovf_ie;
            reg_rdata[CB_BLK_ST] = st[ST_BLK];
            reg_rdata[CB_OVF_ST] = st[ST_OVF];
         end
         A_BLEN:  reg_rdata[BLK_W-1:0]  = blk_len;
         A_BCNT:  reg_rdata[BLK_W-1:0]  = blk_cnt;
         A_PEND:  reg_rdata[EDGE_W-1:0] = pend_cnt;
         A_THR:   reg_rdata[THR_W-1:0]  = thr;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/hsreq_irq_chk.sv
module hsreq_irq_chk #(
   parameter int EDGE_W = 15,
   parameter int BLK_W  = 16,
   parameter int THR_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rise,
   input logic              xfer_done,
   input logic              we_ctrl,
   input logic              we_blen,
   input logic              w1c_blk,
   input logic              w1c_ovf,
   input logic [EDGE_W-1:0] pend_cnt,
   input logic [BLK_W-1:0]  blk_cnt,
   input logic [BLK_W-1:0]  blk_len,
   input logic              hold,
   input logic              blk_ie,
   input logic              ovf_ie,
   input logic              blk_st,
   input logic              ovf_st,
   input logic [THR_W-1:0]  thr,
   input logic              irq
);
   localparam logic [EDGE_W-1:0] PMAX  = '1;
   localparam int                CMP_W = (EDGE_W > THR_W) ? EDGE_W : THR_W;

   AST_PEND_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !xfer_done && pend_cnt != PMAX) |=> pend_cnt == $past(pend_cnt) + EDGE_W'(1)); // R2
   AST_PEND_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && xfer_done) |=> $stable(pend_cnt)); // R2
   AST_PEND_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !rise && pend_cnt == '0) |=> pend_cnt == '0); // R3
   AST_PEND_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !xfer_done && pend_cnt == PMAX) |=> pend_cnt == PMAX); // R3
   AST_BLK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !we_blen && blk_cnt == BLK_W'(1)) |=> blk_cnt == $past(blk_len)); // R4
   AST_BLK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !we_blen && !we_ctrl && !hold && blk_cnt == BLK_W'(1)) |=> blk_st); // R5
   AST_HOLD_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(blk_st) && $past(hold)) |-> pend_cnt == '0); // R6
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (CMP_W'(pend_cnt) > CMP_W'(thr)) |=> ovf_st); // R7
   AST_BLK_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(blk_st) |-> $past(we_ctrl && w1c_blk)); // R8
   AST_OVF_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_st) |-> $past(we_ctrl && w1c_ovf)); // R8
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_ie && !ovf_ie) |-> !irq); // R9
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (blk_st || ovf_st)); // R9
endmodule

bind hsreq_irq_unit hsreq_irq_chk #(.EDGE_W(EDGE_W), .BLK_W(BLK_W), .THR_W(THR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rise      (edge_rise),
   .xfer_done (xfer_done),
   .we_ctrl   (we_ctrl),
   .we_blen   (we_blen),
   .w1c_blk   (w1c[0]),
   .w1c_ovf   (w1c[1]),
   .pend_cnt  (pend_cnt),
   .blk_cnt   (blk_cnt),
   .blk_len   (blk_len),
   .hold      (en.hold),
   .blk_ie    (en.blk_ie),
   .ovf_ie    (en.ovf_ie),
   .blk_st    (st[0]),
   .ovf_st    (st[1]),
   .thr       (thr),
   .irq       (irq)
);

// File: tb/tb_hsreq_irq_unit.sv
module tb_hsreq_irq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_in = 1'b0;
   logic        xfer_done = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        irq;
   logic        req_lvl = 1'b0;
   logic        done = 1'b0;
   int          n_total = 0;
   int          n_fail = 0;

   localparam logic [2:0] CTRL = 3'd0, BLEN = 3'd1, BCNT = 3'd2, PEND = 3'd3, THR = 3'd4;

   typedef struct {
      bit          is_irq;
      logic [15:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sbq[$];

   always #4 clk = ~clk;  // 125 MHz

   hsreq_irq_unit dut (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .xfer_done(xfer_done),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d, input logic xd);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d; xfer_done = xd; req_in = req_lvl;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      step(1'b1, a, d, 1'b0);
   endtask

   task automatic xd1();
      step(1'b0, CTRL, 16'h0, 1'b1);
   endtask

   task automatic pulse();
      req_lvl = 1'b1; step(1'b0, CTRL, 16'h0, 1'b0);
      req_lvl = 1'b0; step(1'b0, CTRL, 16'h0, 1'b0);
   endtask

   task automatic chk_reg(input logic [2:0] a, input logic [15:0] e, input string tag);
      sb_item_t it;
      step(1'b0, a, 16'h0, 1'b0);
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      sb_item_t it;
      step(1'b0, CTRL, 16'h0, 1'b0);
      it.is_irq = 1'b1; it.exp = {15'h0, e}; it.tag = tag;
      sbq.push_back(it);
   endtask

   // monitor: compares queued expectations 2 ns after the driving negedge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sbq.size() > 0) begin
            sb_item_t it;
            logic [15:0] act;
            it = sbq.pop_front();
            act = it.is_irq ? {15'h0, irq} : reg_rdata;
            n_total++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_reg(CTRL, 16'h0000, "R1 ctrl");
      chk_reg(BLEN, 16'h0000, "R1 blen");
      chk_reg(BCNT, 16'h0000, "R1 bcnt");
      chk_reg(PEND, 16'h0000, "R1 pend");
      chk_reg(THR,  16'hFFFF, "R1 thr");
      chk_irq(1'b0, "R1 irq");

      // R2 edge counting
      pulse();
      chk_reg(PEND, 16'd1, "R2 one edge");
      req_lvl = 1'b1;
      repeat (3) step(1'b0, CTRL, 16'h0, 1'b0);
      req_lvl = 1'b0;
      step(1'b0, CTRL, 16'h0, 1'b0);
      chk_reg(PEND, 16'd2, "R2 held level counts once");
      pulse();
      xd1();
      chk_reg(PEND, 16'd2, "R2 inc then dec");
      req_lvl = 1'b1; step(1'b0, CTRL, 16'h0, 1'b1);
      req_lvl = 1'b0; step(1'b0, CTRL, 16'h0, 1'b0);
      chk_reg(PEND, 16'd2, "R2 edge with strobe holds");
      xd1(); xd1(); xd1();
      chk_reg(PEND, 16'd0, "R3 floor at zero");
      chk_reg(BCNT, 16'd0, "R4 zero counter ignores strobes");

      // R4/R5 block counting, status and enable
      wr(BLEN, 16'd3);
      chk_reg(BLEN, 16'd3, "R4 blen written");
      chk_reg(BCNT, 16'd3, "R4 counter loaded");
      xd1();
      chk_reg(BCNT, 16'd2, "R4 decrement");
      xd1();
      chk_reg(CTRL, 16'h0000, "R5 no status mid-block");
      xd1();
      chk_reg(BCNT, 16'd3, "R4 reload at block end");
      chk_reg(CTRL, 16'h0100, "R5 block-done status");
      chk_irq(1'b0, "R9 masked status");
      wr(CTRL, 16'h0001);
      chk_reg(CTRL, 16'h0101, "R8 zero leaves status");
      chk_irq(1'b1, "R9 enabled status");
      wr(CTRL, 16'h0101);
      chk_reg(CTRL, 16'h0001, "R8 one clears status");
      chk_irq(1'b0, "R9 cleared");

      // R6 hold until pending drains
      wr(CTRL, 16'h0003);
      wr(BLEN, 16'd2);
      pulse(); pulse(); pulse();
      xd1(); xd1();
      chk_reg(CTRL, 16'h0003, "R6 withheld while pending");
      xd1();
      chk_reg(CTRL, 16'h0103, "R6 released at zero");
      chk_irq(1'b1, "R6 irq after release");
      chk_reg(PEND, 16'd0, "R6 pending drained");
      wr(CTRL, 16'h0103);

      // R8 set wins over clear in the same clock (block counter is 1)
      wr(CTRL, 16'h0001);
      step(1'b1, CTRL, 16'h0101, 1'b1);
      chk_reg(CTRL, 16'h0101, "R8 set beats clear");
      chk_reg(BCNT, 16'd2, "R4 reload during write");
      wr(CTRL, 16'h0101);
      chk_reg(CTRL, 16'h0001, "R8 later clear");

      // R7 overflow
      wr(THR, 16'd2);
      wr(CTRL, 16'h0004);
      pulse(); pulse();
      chk_reg(CTRL, 16'h0004, "R7 at threshold no overflow");
      pulse();
      chk_reg(CTRL, 16'h0204, "R7 overflow status");
      chk_irq(1'b1, "R9 overflow irq");
      wr(CTRL, 16'h0204);
      chk_reg(CTRL, 16'h0204, "R8 overflow set beats clear");
      xd1();
      wr(CTRL, 16'h0204);
      chk_reg(CTRL, 16'h0004, "R8 overflow cleared");
      chk_irq(1'b0, "R9 overflow irq gone");

      // R3 saturation
      wr(THR, 16'hFFFF);
      repeat (32767) pulse();
      pulse(); pulse();
      chk_reg(PEND, 16'h7FFF, "R3 ceiling");
      xd1();
      chk_reg(PEND, 16'h7FFE, "R3 leaves ceiling");

      // R4 read-only addresses and zero length
      wr(PEND, 16'h1234);
      chk_reg(PEND, 16'h7FFE, "R4 pend write ignored");
      wr(BCNT, 16'd7);
      chk_reg(BCNT, 16'd2, "R4 bcnt write ignored");
      wr(BLEN, 16'd0);
      xd1();
      chk_reg(BCNT, 16'd0, "R4 zero length stays");

      step(1'b0, CTRL, 16'h0, 1'b0);
      step(1'b0, CTRL, 16'h0, 1'b0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule